// File: doc/BRIEF.md
# Interleaved Memory Address Translator

This block turns the right-justified port address seen by one memory channel into the real address that the rest of the system uses. It is given the group shape: how many channels share the group (1, 2, 3, 4, 6 or 8), the channel's group ID, a group-size mask and a base address. From these it rebuilds the system view. The group-select bits that the channel interleave removed are put back above the 128-byte line offset. The base address is placed at bit 32 and up.

A group of three or six channels has no plain select field. The channel is picked by a mod-3 hash of the address. For such a group the two hidden high port bits are recovered from the hash and placed just above the group-size boundary. A range mode takes a start and an end port address in the same cycle. In that mode the recovered bits are forced to fixed values, so that the start never lands above the end. A channel count that is not in the supported set raises an error instead of giving an address.

The result is registered: a request taken on one rising edge gives its response on the next edge.

Top module: `addr_xlate`

## Requirements
- R1: For a channel count of 1, 2, 4 or 8 (chan_cnt_i holds the count as a plain binary number), the output keeps port bits [6:0] in place. Port bits [39:7] are shifted up by w bits, where w is 0, 1, 2 or 3 for those four counts. The low w bits of grp_id_i go to bits [7+w-1:7].
- R2: A count of 3 inserts no group bits, in the same way as count 1. A count of 6 inserts grp_id_i bit 0 at bit 7, in the same way as count 2. Both counts then also receive a 2-bit recovered value.
- R3: The 2-bit recovered value is ORed in with its LSB at bit 30 + (number of set bits in grp_size_i).
- R4: In single mode the recovered value is (g - r - h) mod 3, computed on the address after group-bit insertion. Here h = a[16:15] + a[18:17] + a[20:19], r = a[8:7] and g = grp_id_i. For count 6, g = grp_id_i & 3'b110 and r = {a[8], 1'b0}.
- R5: In range mode (range_mode_i = 1) with count 3 or 6, the start result (addr_a_o, from port_a_i) uses recovered value 2'b00. The end result (addr_b_o, from port_b_i) uses 2'b10.
- R6: base_addr_i is ORed into the result at bits [55:32].
- R7: Any chan_cnt_i outside {1,2,3,4,6,8} sets err_o, keeps rsp_valid_o low and drives both addresses to zero.
- R8: Outputs update one clock after a rising edge on which req_valid_i is high. rsp_valid_o follows req_valid_i with that latency. Reset clears all outputs to zero.
- R9: In single mode port_b_i is ignored and addr_b_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| range_mode_i | input | 1 | 0: single address, 1: start/end pair |
| port_a_i | input | 40 | Port address (single) or range start |
| port_b_i | input | 40 | Range end port address |
| chan_cnt_i | input | 4 | Channels per group, binary count |
| grp_id_i | input | 3 | Group ID of this channel |
| grp_size_i | input | 11 | Group-size mask |
| base_addr_i | input | 24 | Group base address |
| rsp_valid_o | output | 1 | Result valid |
| err_o | output | 1 | Unsupported channel count |
| addr_a_o | output | 56 | Real address or range start |
| addr_b_o | output | 56 | Range end, zero in single mode |

## Verification
A table of port addresses, group IDs, masks and base values is run through every supported channel count, once in single mode and once in range mode. Comparing the two modes shows the hash-derived value apart from the forced 00/10 values. Directed cases with hand-derived results isolate each piece on its own: a lone base address, a full 11-bit mask moving the recovered bits to bit 41, and a count-6 input in which the inserted ID bit must be left out of the hash. Each unsupported count is applied to check the error path.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
  localparam int PORT_AW  = 40;
  localparam int SYS_AW   = 56;
  localparam int GID_W    = 3;
  localparam int GSZ_W    = 11;
  localparam int BAR_W    = 24;
  localparam int CNT_W    = 4;
  localparam int KEEP_LO  = 7;
  localparam int BAR_LSB  = 32;
  localparam int MSB_LSB  = 30;
  localparam int HASH_LSB = 15;
  localparam int HASH_N   = 3;

  typedef enum logic [1:0] {MSB_HASH, MSB_ZERO, MSB_TWO} msb_src_e;

  function automatic logic cnt_ok(input logic [CNT_W-1:0] c);
    return (c == 1) || (c == 2) || (c == 3) || (c == 4) || (c == 6) || (c == 8);
  endfunction

  function automatic logic cnt_mod3(input logic [CNT_W-1:0] c);
    return (c == 3) || (c == 6);
  endfunction

  function automatic logic [1:0] cnt_width(input logic [CNT_W-1:0] c);
    case (c)
      4'd2, 4'd6: return 2'd1;
      4'd4:       return 2'd2;
      4'd8:       return 2'd3;
      default:    return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/addr_grp_insert.sv
module addr_grp_insert
  import addr_xlate_pkg::*;
(
  input  logic [PORT_AW-1:0] port_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [GID_W-1:0]   gid_i,
  output logic [SYS_AW-1:0]  ins_o
);
  localparam int NW = 4;
  logic [SYS_AW-1:0] cand [NW];

  for (genvar w = 0; w < NW; w++) begin : g_w
    localparam logic [GID_W-1:0] MASK = GID_W'((1 << w) - 1);
    assign cand[w] = (SYS_AW'(port_i[PORT_AW-1:KEEP_LO]) << (KEEP_LO + w))
                   | (SYS_AW'(gid_i & MASK) << KEEP_LO)
                   | SYS_AW'(port_i[KEEP_LO-1:0]);
  end

  assign ins_o = cand[cnt_width(cnt_i)];

  always_comb begin
    AST_LOW_KEEP: assert (ins_o[KEEP_LO-1:0] == port_i[KEEP_LO-1:0]); // R1
  end
endmodule

// File: rtl/addr_mod3_solver.sv
module addr_mod3_solver
  import addr_xlate_pkg::*;
(
  input  logic [SYS_AW-1:0] ins_i,
  input  logic              six_i,
  input  logic [GID_W-1:0]  gid_i,
  output logic [1:0]        msb_o
);
  localparam int ACC_W = 5;
  localparam int BIAS  = 12; // multiple of 3, keeps the sum non-negative

  logic [ACC_W-1:0] hsum;
  logic [ACC_W-1:0] g, r, acc;

  always_comb begin
    hsum = '0;
    for (int k = 0; k < HASH_N; k++)
      hsum = hsum + ACC_W'(ins_i[HASH_LSB + 2*k +: 2]);
    g   = six_i ? ACC_W'(gid_i & 3'b110) : ACC_W'(gid_i);
    r   = six_i ? ACC_W'({ins_i[KEEP_LO+1], 1'b0}) : ACC_W'(ins_i[KEEP_LO +: 2]);
    acc = g + ACC_W'(BIAS) - r - hsum;
    msb_o = 2'(acc % ACC_W'(3));
  end

  always_comb begin
    AST_MSB_LEGAL: assert (msb_o != 2'd3); // R4
  end
endmodule

// File: rtl/addr_lane.sv
module addr_lane
  import addr_xlate_pkg::*;
(
  input  logic [PORT_AW-1:0] port_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [GID_W-1:0]   gid_i,
  input  logic [GSZ_W-1:0]   gsz_i,
  input  logic [BAR_W-1:0]   bar_i,
  input  msb_src_e           src_i,
  output logic [SYS_AW-1:0]  sys_o
);
  logic [SYS_AW-1:0] ins;
  logic [1:0]        hashed, msb;
  logic [5:0]        pos;

  addr_grp_insert u_ins (.port_i(port_i), .cnt_i(cnt_i), .gid_i(gid_i), .ins_o(ins));

  addr_mod3_solver u_m3 (.ins_i(ins), .six_i(cnt_i == 4'd6), .gid_i(gid_i), .msb_o(hashed));

  always_comb begin
    case (src_i)
      MSB_ZERO: msb = 2'b00;
      MSB_TWO:  msb = 2'b10;
      default:  msb = hashed;
    endcase
    pos   = 6'(MSB_LSB) + 6'($countones(gsz_i));
    sys_o = ins | (SYS_AW'(bar_i) << BAR_LSB);
    if (cnt_mod3(cnt_i)) sys_o = sys_o | (SYS_AW'(msb) << pos);
  end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import addr_xlate_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               range_mode_i,
  input  logic [PORT_AW-1:0] port_a_i,
  input  logic [PORT_AW-1:0] port_b_i,
  input  logic [CNT_W-1:0]   chan_cnt_i,
  input  logic [GID_W-1:0]   grp_id_i,
  input  logic [GSZ_W-1:0]   grp_size_i,
  input  logic [BAR_W-1:0]   base_addr_i,
  output logic               rsp_valid_o,
  output logic               err_o,
  output logic [SYS_AW-1:0]  addr_a_o,
  output logic [SYS_AW-1:0]  addr_b_o
);
  localparam int NL = 2;

  logic [PORT_AW-1:0] lane_port [NL];
  msb_src_e           lane_src  [NL];
  logic [SYS_AW-1:0]  lane_sys  [NL];
  logic               ok;

  assign lane_port[0] = port_a_i;
  assign lane_port[1] = port_b_i;
  assign lane_src[0]  = range_mode_i ? MSB_ZERO : MSB_HASH;
  assign lane_src[1]  = MSB_TWO;
  assign ok = cnt_ok(chan_cnt_i);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    addr_lane u_lane (
      .port_i(lane_port[l]), .cnt_i(chan_cnt_i), .gid_i(grp_id_i),
      .gsz_i(grp_size_i), .bar_i(base_addr_i), .src_i(lane_src[l]),
      .sys_o(lane_sys[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      addr_a_o    <= '0;
      addr_b_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && ok;
      err_o       <= req_valid_i && !ok;
      if (req_valid_i) begin
        addr_a_o <= ok ? lane_sys[0] : '0;
        addr_b_o <= (ok && range_mode_i) ? lane_sys[1] : '0;
      end
    end
  end

  AST_ERR_BLOCKS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rsp_valid_o); // R7
  AST_BAD_CNT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cnt_ok(chan_cnt_i)) |=> (err_o && addr_a_o == '0 && addr_b_o == '0)); // R7
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_valid_o || err_o)); // R8
  AST_SINGLE_END_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !range_mode_i) |=> addr_b_o == '0); // R9
  AST_RANGE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && range_mode_i && port_a_i == port_b_i && cnt_ok(chan_cnt_i))
      |=> addr_a_o <= addr_b_o); // R5
endmodule

// File: tb/addr_xlate_bench.sv
module addr_xlate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, rng = 1'b0;
  logic [39:0] pa = '0, pb = '0;
  logic [3:0]  cnt = 4'd1;
  logic [2:0]  gid = '0;
  logic [10:0] gsz = '0;
  logic [23:0] bar = '0;
  logic        vld, err;
  logic [55:0] oa, ob;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  addr_xlate u_addr_xlate (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .range_mode_i(rng),
    .port_a_i(pa), .port_b_i(pb), .chan_cnt_i(cnt), .grp_id_i(gid),
    .grp_size_i(gsz), .base_addr_i(bar), .rsp_valid_o(vld), .err_o(err),
    .addr_a_o(oa), .addr_b_o(ob)
  );

  // mode: 0 hash, 1 force 00, 2 force 10
  function automatic logic [55:0] model(input logic [3:0] c, input logic [2:0] g,
      input logic [10:0] s, input logic [23:0] b, input logic [39:0] p, input int mode);
    logic [55:0] a;
    int w, h, rr, gg, r3, m, ones;
    w = (c == 2 || c == 6) ? 1 : (c == 4) ? 2 : (c == 8) ? 3 : 0;
    a = ({16'd0, p} >> 7) << (7 + w);
    a = a | (56'((g & 3'((1 << w) - 1))) << 7) | 56'(p[6:0]);
    if (c == 3 || c == 6) begin
      h  = (int'(a[16:15]) + int'(a[18:17]) + int'(a[20:19])) % 3;
      gg = (c == 6) ? int'(g & 3'b110) : int'(g);
      rr = (c == 6) ? (a[8] ? 2 : 0) : int'(a[8:7]);
      r3 = (gg % 3 + 3 - rr % 3) % 3;
      m = 0;
      while (r3 != h) begin r3 = (r3 + 2) % 3; m++; end
      if (mode == 1) m = 0;
      if (mode == 2) m = 2;
      ones = 0;
      for (int i = 0; i < 11; i++) ones += int'(s[i]);
      a = a | (56'(m) << (30 + ones));
    end
    return a | (56'(b) << 32);
  endfunction

  task automatic chk(input string req_tag, input logic [55:0] act, input logic [55:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic issue(input logic r, input logic [3:0] c, input logic [2:0] g,
      input logic [10:0] s, input logic [23:0] b, input logic [39:0] a, input logic [39:0] e);
    @(negedge clk);
    req = 1'b1; rng = r; cnt = c; gid = g; gsz = s; bar = b; pa = a; pb = e;
    @(negedge clk);
    req = 1'b0;
  endtask

  localparam int NV = 12;
  // {cnt, gid, gsz, bar, port}
  localparam logic [81:0] VEC [NV] = '{
    {4'd1, 3'd5, 11'h000, 24'h000000, 40'h00_1234_5678},
    {4'd2, 3'd3, 11'h001, 24'h000010, 40'h12_3456_789A},
    {4'd4, 3'd6, 11'h003, 24'hF00001, 40'hFF_FFFF_FFFF},
    {4'd8, 3'd7, 11'h00F, 24'h123456, 40'h80_0000_0081},
    {4'd3, 3'd0, 11'h000, 24'h000001, 40'h00_0018_8180},
    {4'd3, 3'd2, 11'h007, 24'h000000, 40'h00_000A_8000},
    {4'd3, 3'd5, 11'h3FF, 24'hABCDEF, 40'h00_001F_FF80},
    {4'd6, 3'd1, 11'h001, 24'h000002, 40'h00_0000_0100},
    {4'd6, 3'd6, 11'h00F, 24'h000000, 40'h00_0005_4280},
    {4'd6, 3'd3, 11'h7FF, 24'h7FFFFF, 40'h00_1234_5680},
    {4'd3, 3'd7, 11'h01F, 24'h00ABCD, 40'h00_0007_8001},
    {4'd6, 3'd4, 11'h003, 24'h100000, 40'h00_000F_807F}
  };

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R8 reset valid", 56'(vld), 56'd0);
    chk("R8 reset addr", oa | ob, 56'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] c; logic [2:0] g; logic [10:0] s; logic [23:0] b; logic [39:0] p;
      {c, g, s, b, p} = VEC[i];
      issue(1'b0, c, g, s, b, p, ~p);
      chk((c == 3 || c == 6) ? "R4 single" : "R1 single", oa, model(c, g, s, b, p, 0));
      chk("R9 end zero", ob, 56'd0);
      chk("R8 valid", 56'(vld), 56'd1);
      issue(1'b1, c, g, s, b, p, p ^ 40'h00_0001_8080);
      chk("R5 start", oa, model(c, g, s, b, p, 1));
      chk("R5 end", ob, model(c, g, s, b, p ^ 40'h00_0001_8080, 2));
    end

    issue(1'b0, 4'd1, 3'd0, 11'h0, 24'h0, 40'h1_2345, 40'h0);
    chk("R1 plain", oa, 56'h1_2345);
    issue(1'b0, 4'd2, 3'd1, 11'h0, 24'h1, 40'h80, 40'h0);
    chk("R1 two-way", oa, 56'h1_0000_0180);
    issue(1'b0, 4'd1, 3'd0, 11'h0, 24'hABCDEF, 40'h5, 40'h0);
    chk("R6 base", oa, 56'hAB_CDEF_0000_0005);
    issue(1'b0, 4'd3, 3'd1, 11'h0, 24'h0, 40'h0, 40'h0);
    chk("R4 three-way", oa, 56'h4000_0000);
    issue(1'b1, 4'd3, 3'd1, 11'h0, 24'h0, 40'h0, 40'h0);
    chk("R5 start forced", oa, 56'h0);
    chk("R5 end forced", ob, 56'h8000_0000);
    issue(1'b0, 4'd3, 3'd1, 11'h7FF, 24'h0, 40'h0, 40'h0);
    chk("R3 full mask", oa, 56'h200_0000_0000);
    issue(1'b0, 4'd6, 3'd1, 11'h0, 24'h0, 40'h80, 40'h0);
    chk("R2 six-way", oa, 56'h4000_0180);
    issue(1'b0, 4'd6, 3'd1, 11'h0, 24'h0, 40'h80, 40'hFF_FFFF_FFFF);
    chk("R9 end ignored", ob, 56'h0);

    foreach (VEC[k]) begin end
    for (int bad = 0; bad < 16; bad++) begin
      if (bad == 1 || bad == 2 || bad == 3 || bad == 4 || bad == 6 || bad == 8) continue;
      issue(1'b1, 4'(bad), 3'd1, 11'h1, 24'hFF, 40'h1234, 40'h5678);
      chk("R7 err", 56'(err), 56'd1);
      chk("R7 valid", 56'(vld), 56'd0);
      chk("R7 addr", oa | ob, 56'd0);
    end

    @(negedge clk);
    chk("R8 idle valid", 56'(vld), 56'd0);
    chk("R8 idle err", 56'(err), 56'd0);

    issue(1'b0, 4'd8, 3'd2, 11'h0, 24'h3, 40'h100, 40'h0);
    rst_n = 1'b0;
    #1;
    chk("R8 async reset", oa, 56'd0);
    chk("R8 async reset valid", 56'(vld), 56'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule